// File: doc/BRIEF.md
# Clock Synthesizer Control Registers

This block is the register front end of a clock synthesizer. The synthesizer has a reference divider, an integer multiplier with a fractional part, a sigma-delta setting and four post-dividers. Software writes divider ratios, output enables, the reference choice and the oscillator range over a plain 32-bit register bus. These values go into staged registers first. They reach the synthesizer only when software sets a self-clearing commit bit. The commit copies every staged configuration field into the active set that drives the synthesizer pins.

After a commit, the block models the analog loop with a lock flag. The flag drops and then returns after a delay in cycles that software programs. Each post-divider output has an acknowledge that trails its active enable by a fixed number of cycles. A bypass setting forces all acknowledges off. After reset, a short sequencer holds off every bus write until a reset-done flag rises. The two spread-spectrum words are plain storage.

Top module: `clksynth_regs`

## Requirements
- R1: During reset and after its release, every register reads 0, every synthesizer output is 0, and the lock flag is 0.
- R2: Reset-done (status bit 0) rises at the 16th rising edge after reset release and then stays high. Any bus write at an edge where reset-done is still low is ignored.
- R3: Byte addresses are: 0x00 control, 0x04 status, 0x08 commit, 0x0C config 1, 0x10 config 2, 0x14 config 3, 0x18 and 0x1C spread-spectrum words, 0x20 config 4. Writable words read back as written, except the control word, which keeps bits 15:0 only. Any other address reads 0.
- R4: Writes to configuration words change no synthesizer output until a commit.
- R5: Writing a word with bit 0 set to address 0x08 makes bit 0 of that register read 1 for exactly one cycle. At the next edge, bit 0 returns to 0 and the active settings take the staged values. A write with bit 0 clear has no effect.
- R6: Active fields are decoded as follows:
  - config 1: multiplier in bits 20:9 and reference ratio-minus-one in bits 8:1.
  - config 3: sigma-delta in bits 17:10, post-divider 1 in bits 6:0, post-divider 2 in bits 24:18 and post-divider 3 in bits 31:25.
  - config 4: post-divider 0 in bits 24:18 and the fraction in bits 17:0.
  - config 2: range code in bits 3:1 (2 low, 4 high), divide-by-two in bit 12, reference enable in bit 13, output-clock enable in bit 14, bypass in bit 20 and reference select in bits 22:21.
- R7: The lock flag (status bit 1 and `syn_locked`) clears at the edge that takes a commit write. It sets again D+1 edges later, where D is control bits 15:0.
- R8: A commit write taken while the lock count is running reloads the count, so lock comes D+1 edges after the latest commit.
- R9: Output enables sit in config 2 bits 16, 18, 23 and 25, for outputs 0 to 3. Each output's acknowledge goes high 4 edges after its active enable changes. The acknowledges appear in status bits 7, 8, 10 and 11 and on `syn_div_ack[3:0]`.
- R10: While the active bypass bit is set, all acknowledges read 0, starting in the cycle the bypass becomes active.
- R11: The status register is read-only: writes to it leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| syn_ref_div_m1 | output | 8 | Active reference ratio minus one |
| syn_mult | output | 12 | Active integer multiplier |
| syn_frac | output | 18 | Active fractional multiplier |
| syn_sd | output | 8 | Active sigma-delta setting |
| syn_post_div_m1 | output | 28 | Four 7-bit post-divider ratios minus one, output 0 in bits 6:0 |
| syn_out_en | output | 4 | Active post-divider output enables |
| syn_bypass | output | 1 | Active post-divider bypass |
| syn_ref_en | output | 1 | Active reference enable |
| syn_clkout_en | output | 1 | Active downstream clock enable |
| syn_ref_sel | output | 2 | Active reference select (3 = system clock) |
| syn_range | output | 3 | Active oscillator range code |
| syn_hf_div2 | output | 1 | Active high-frequency divide-by-two |
| syn_locked | output | 1 | Modelled loop lock |
| syn_div_ack | output | 4 | Post-divider enable acknowledges |
| reset_done | output | 1 | Reset sequence complete |

## Verification
The bench first writes a configuration word before reset-done rises, which separates a gated write from an accepted one. It then stages a full configuration with distinct non-zero values in every field. The outputs are read before and after the commit, which exposes both premature application and swapped or misplaced field slices. The commit is timed cycle by cycle with a lock delay of 5. A second commit is issued three cycles into the count, which separates a reloading counter from a free-running one. Finally, a bypass commit is checked against the acknowledges in the same cycle. It is followed by a commit write with bit 0 clear and a write to the status word, both of which must leave the lock and status unchanged.

// File: rtl/clksynth_pkg.sv
// Shared constants, the decoded configuration type and the field decoder
// for the clock synthesizer register block.
package clksynth_pkg;

    // Byte addresses of the register words
    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_STATUS = 8'h04;
    localparam logic [7:0] A_COMMIT = 8'h08;
    localparam logic [7:0] A_CFG1   = 8'h0C;
    localparam logic [7:0] A_CFG2   = 8'h10;
    localparam logic [7:0] A_CFG3   = 8'h14;
    localparam logic [7:0] A_SPR1   = 8'h18;
    localparam logic [7:0] A_SPR2   = 8'h1C;
    localparam logic [7:0] A_CFG4   = 8'h20;

    localparam int NUM_OUT = 4;
    localparam int PD_W    = 7;

    // Config 2 single-bit controls
    localparam int C2_HFDIV  = 12;
    localparam int C2_REFEN  = 13;
    localparam int C2_CLKOEN = 14;
    localparam int C2_BYPASS = 20;

    // Enable bit in config 2 and acknowledge bit in status, per output
    localparam int EN_POS  [NUM_OUT] = '{16, 18, 23, 25};
    localparam int ACK_POS [NUM_OUT] = '{7, 8, 10, 11};

    localparam int ST_RDONE = 0;
    localparam int ST_LOCK  = 1;

    typedef struct packed {
        logic [7:0]                  ref_div_m1;
        logic [11:0]                 mult;
        logic [17:0]                 frac;
        logic [7:0]                  sd;
        logic [NUM_OUT-1:0][PD_W-1:0] post_div_m1;
        logic [NUM_OUT-1:0]          out_en;
        logic                        bypass;
        logic                        ref_en;
        logic                        clkout_en;
        logic [1:0]                  ref_sel;
        logic [2:0]                  range_sel;
        logic                        hf_div2;
    } synth_cfg_t;

    // Slices the four configuration words into synthesizer fields
    function automatic synth_cfg_t decode_cfg(input logic [31:0] w1, input logic [31:0] w2,
                                              input logic [31:0] w3, input logic [31:0] w4);
        synth_cfg_t c;
        c.ref_div_m1     = w1[8:1];
        c.mult           = w1[20:9];
        c.sd             = w3[17:10];
        c.post_div_m1[1] = w3[6:0];
        c.post_div_m1[2] = w3[24:18];
        c.post_div_m1[3] = w3[31:25];
        c.post_div_m1[0] = w4[24:18];
        c.frac           = w4[17:0];
        for (int i = 0; i < NUM_OUT; i++) c.out_en[i] = w2[EN_POS[i]];
        c.bypass         = w2[C2_BYPASS];
        c.ref_en         = w2[C2_REFEN];
        c.clkout_en      = w2[C2_CLKOEN];
        c.ref_sel        = w2[22:21];
        c.range_sel      = w2[3:1];
        c.hf_div2        = w2[C2_HFDIV];
        return c;
    endfunction

endpackage

// File: rtl/clksynth_reset_seq.sv
// Reset-done sequencer: counts RESET_CYCLES edges after reset release and
// then raises done for good. Assumes RESET_CYCLES >= 2.
module clksynth_reset_seq #(
    parameter int RESET_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(RESET_CYCLES);

    logic [CW-1:0] cnt;

    // Count post-reset edges and latch done on the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == CW'(RESET_CYCLES - 1)) done <= 1'b1;
            else                              cnt  <= cnt + 1'b1;
        end
    end

    p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/clksynth_regfile.sv
// Bus-facing register file: staged words, the self-clearing commit bit, the
// copy of staged fields into the active set, and the read multiplexer.
// Assumes LOCK_W <= 32. Writes are dropped until rst_done is high.
module clksynth_regfile
    import clksynth_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LOCK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_done,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [31:0]       status_word,
    output logic [31:0]       rdata,
    output synth_cfg_t        act_cfg,
    output logic [LOCK_W-1:0] lock_delay,
    output logic              go_start,
    output logic              go_pend
);
    logic [31:0] stg_cfg1, stg_cfg2, stg_cfg3, stg_cfg4, spr1, spr2;
    logic        wr_ok;

    assign wr_ok    = wr_en && rst_done;
    assign go_start = wr_ok && (addr == ADDR_W'(A_COMMIT)) && wdata[0];

    // Capture accepted writes into the staged words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_cfg1   <= '0;
            stg_cfg2   <= '0;
            stg_cfg3   <= '0;
            stg_cfg4   <= '0;
            spr1       <= '0;
            spr2       <= '0;
            lock_delay <= '0;
        end else if (wr_ok) begin
            if (addr == ADDR_W'(A_CTRL)) lock_delay <= wdata[LOCK_W-1:0];
            if (addr == ADDR_W'(A_CFG1)) stg_cfg1   <= wdata;
            if (addr == ADDR_W'(A_CFG2)) stg_cfg2   <= wdata;
            if (addr == ADDR_W'(A_CFG3)) stg_cfg3   <= wdata;
            if (addr == ADDR_W'(A_CFG4)) stg_cfg4   <= wdata;
            if (addr == ADDR_W'(A_SPR1)) spr1       <= wdata;
            if (addr == ADDR_W'(A_SPR2)) spr2       <= wdata;
        end
    end

    // Hold the commit bit for one cycle, then apply staged to active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_pend <= 1'b0;
            act_cfg <= '0;
        end else begin
            go_pend <= go_start;
            if (go_pend) act_cfg <= decode_cfg(stg_cfg1, stg_cfg2, stg_cfg3, stg_cfg4);
        end
    end

    // Select the read word by address
    always_comb begin
        rdata = '0;
        if      (addr == ADDR_W'(A_CTRL))   rdata = 32'(lock_delay);
        else if (addr == ADDR_W'(A_STATUS)) rdata = status_word;
        else if (addr == ADDR_W'(A_COMMIT)) rdata = {31'b0, go_pend};
        else if (addr == ADDR_W'(A_CFG1))   rdata = stg_cfg1;
        else if (addr == ADDR_W'(A_CFG2))   rdata = stg_cfg2;
        else if (addr == ADDR_W'(A_CFG3))   rdata = stg_cfg3;
        else if (addr == ADDR_W'(A_SPR1))   rdata = spr1;
        else if (addr == ADDR_W'(A_SPR2))   rdata = spr2;
        else if (addr == ADDR_W'(A_CFG4))   rdata = stg_cfg4;
    end

    p_go_selfclear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pend && !go_start) |=> !go_pend);

    p_apply_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        go_pend |=> (act_cfg.mult == $past(stg_cfg1[20:9])));

    p_early_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_done && wr_en) |=> ($stable(stg_cfg2) && $stable(stg_cfg1)));

endmodule

// File: rtl/clksynth_lock_timer.sv
// Lock model: a commit drops lock and loads the programmed delay; lock rises
// one edge after the count reaches zero. A new commit reloads the count.
module clksynth_lock_timer #(
    parameter int LOCK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LOCK_W-1:0] delay,
    output logic              locked
);
    logic [LOCK_W-1:0] cnt;
    logic              busy;

    // Run the lock countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            busy   <= 1'b0;
            locked <= 1'b0;
        end else if (start) begin
            cnt    <= delay;
            busy   <= 1'b1;
            locked <= 1'b0;
        end else if (busy) begin
            if (cnt == '0) begin
                locked <= 1'b1;
                busy   <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    p_lock_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !locked);

    p_lock_from_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(cnt) == '0 && $past(busy)));

endmodule

// File: rtl/clksynth_ack_pipe.sv
// Per-output acknowledge: each active enable passes through an ACK_DELAY
// stage shift chain; bypass masks all acknowledges at once. ACK_DELAY >= 2.
module clksynth_ack_pipe #(
    parameter int N_OUT     = 4,
    parameter int ACK_DELAY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] en,
    input  logic             bypass,
    output logic [N_OUT-1:0] ack
);
    logic [N_OUT-1:0][ACK_DELAY-1:0] chain;

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        // Delay one output's enable by ACK_DELAY edges
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= {chain[i][ACK_DELAY-2:0], en[i]};
        end
        assign ack[i] = chain[i][ACK_DELAY-1] && !bypass;
    end

endmodule

// File: rtl/clksynth_regs.sv
// Top of the clock synthesizer register block. Joins the reset sequencer,
// register file, lock model and acknowledge pipe, and builds the status word.
module clksynth_regs
    import clksynth_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int LOCK_W       = 16,
    parameter int ACK_DELAY    = 4,
    parameter int RESET_CYCLES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr_en,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [7:0]              syn_ref_div_m1,
    output logic [11:0]             syn_mult,
    output logic [17:0]             syn_frac,
    output logic [7:0]              syn_sd,
    output logic [NUM_OUT*PD_W-1:0] syn_post_div_m1,
    output logic [NUM_OUT-1:0]      syn_out_en,
    output logic                    syn_bypass,
    output logic                    syn_ref_en,
    output logic                    syn_clkout_en,
    output logic [1:0]              syn_ref_sel,
    output logic [2:0]              syn_range,
    output logic                    syn_hf_div2,
    output logic                    syn_locked,
    output logic [NUM_OUT-1:0]      syn_div_ack,
    output logic                    reset_done
);
    synth_cfg_t        act;
    logic [LOCK_W-1:0] lock_delay;
    logic              go_start, go_pend;
    logic [31:0]       status_word;

    clksynth_reset_seq #(.RESET_CYCLES(RESET_CYCLES)) u_rseq (
        .clk(clk), .rst_n(rst_n), .done(reset_done));

    clksynth_regfile #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .rst_done(reset_done),
        .wr_en(bus_wr_en), .addr(bus_addr), .wdata(bus_wdata),
        .status_word(status_word), .rdata(bus_rdata), .act_cfg(act),
        .lock_delay(lock_delay), .go_start(go_start), .go_pend(go_pend));

    clksynth_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .start(go_start), .delay(lock_delay),
        .locked(syn_locked));

    clksynth_ack_pipe #(.N_OUT(NUM_OUT), .ACK_DELAY(ACK_DELAY)) u_ack (
        .clk(clk), .rst_n(rst_n), .en(act.out_en), .bypass(act.bypass),
        .ack(syn_div_ack));

    // Assemble the read-only status word
    always_comb begin
        status_word           = '0;
        status_word[ST_RDONE] = reset_done;
        status_word[ST_LOCK]  = syn_locked;
        for (int i = 0; i < NUM_OUT; i++) status_word[ACK_POS[i]] = syn_div_ack[i];
    end

    assign syn_ref_div_m1  = act.ref_div_m1;
    assign syn_mult        = act.mult;
    assign syn_frac        = act.frac;
    assign syn_sd          = act.sd;
    assign syn_post_div_m1 = act.post_div_m1;
    assign syn_out_en      = act.out_en;
    assign syn_bypass      = act.bypass;
    assign syn_ref_en      = act.ref_en;
    assign syn_clkout_en   = act.clkout_en;
    assign syn_ref_sel     = act.ref_sel;
    assign syn_range       = act.range_sel;
    assign syn_hf_div2     = act.hf_div2;

    p_bypass_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        syn_bypass |-> (syn_div_ack == '0));

    p_commit_needs_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go_pend |-> reset_done);

endmodule

// File: tb/clksynth_regs_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, a monitor compares
// them against the design just after each falling edge.
module clksynth_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  syn_ref_div_m1;
    logic [11:0] syn_mult;
    logic [17:0] syn_frac;
    logic [7:0]  syn_sd;
    logic [27:0] syn_post_div_m1;
    logic [3:0]  syn_out_en;
    logic        syn_bypass, syn_ref_en, syn_clkout_en;
    logic [1:0]  syn_ref_sel;
    logic [2:0]  syn_range;
    logic        syn_hf_div2, syn_locked, reset_done;
    logic [3:0]  syn_div_ack;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic mon_req = 1'b0;
    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam int K_RD = 0, K_LOCK = 1, K_ACK = 2, K_REFDIV = 3, K_MULT = 4,
                   K_PDIV = 5, K_FRAC = 6, K_MISC = 7, K_SD = 8, K_OUTEN = 9;

    always #2 clk = ~clk;

    clksynth_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .syn_ref_div_m1(syn_ref_div_m1), .syn_mult(syn_mult), .syn_frac(syn_frac),
        .syn_sd(syn_sd), .syn_post_div_m1(syn_post_div_m1), .syn_out_en(syn_out_en),
        .syn_bypass(syn_bypass), .syn_ref_en(syn_ref_en), .syn_clkout_en(syn_clkout_en),
        .syn_ref_sel(syn_ref_sel), .syn_range(syn_range), .syn_hf_div2(syn_hf_div2),
        .syn_locked(syn_locked), .syn_div_ack(syn_div_ack), .reset_done(reset_done));

    function automatic logic [31:0] probe(input int k);
        case (k)
            K_RD:     return bus_rdata;
            K_LOCK:   return {31'b0, syn_locked};
            K_ACK:    return {28'b0, syn_div_ack};
            K_REFDIV: return {24'b0, syn_ref_div_m1};
            K_MULT:   return {20'b0, syn_mult};
            K_PDIV:   return {4'b0, syn_post_div_m1};
            K_FRAC:   return {14'b0, syn_frac};
            K_MISC:   return {23'b0, syn_hf_div2, syn_range, syn_ref_sel,
                              syn_clkout_en, syn_ref_en, syn_bypass};
            K_SD:     return {24'b0, syn_sd};
            default:  return {28'b0, syn_out_en};
        endcase
    endfunction

    // Monitor: pop and compare one expected item per requested cycle
    always begin
        @(negedge clk);
        #1;
        if (mon_req && kind_q.size() > 0) begin
            automatic int          k = kind_q.pop_front();
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string       t = tag_q.pop_front();
            automatic logic [31:0] a = probe(k);
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: actual=%h expected=%h", t, a, e);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic expect_val(input int k, input logic [7:0] a, input logic [31:0] e,
                              input string tag);
        bus_addr = a;
        kind_q.push_back(k);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        mon_req = 1'b1;
        @(negedge clk);
        mon_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=running expected=done");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_val(K_RD, 8'h04, 32'h0, "R1 status");
        expect_val(K_RD, 8'h0C, 32'h0, "R1 cfg1");
        expect_val(K_LOCK, 8'h00, 32'h0, "R1 lock");
        // R2 early write dropped
        bus_write(8'h0C, 32'h0000FFFF);
        expect_val(K_RD, 8'h0C, 32'h0, "R2 early write");
        idle(10);
        expect_val(K_RD, 8'h04, 32'h0, "R2 done after 15 edges");
        expect_val(K_RD, 8'h04, 32'h1, "R2 done at 16th edge");

        // R3 staging and readback
        bus_write(8'h00, 32'hABCD0005);
        bus_write(8'h0C, 32'h0000C806);
        bus_write(8'h10, 32'h00657008);
        bus_write(8'h14, 32'h12096806);
        bus_write(8'h20, 32'h000D2345);
        bus_write(8'h18, 32'hDEADBEEF);
        bus_write(8'h1C, 32'h0BADF00D);
        expect_val(K_RD, 8'h00, 32'h5, "R3 control");
        expect_val(K_RD, 8'h0C, 32'h0000C806, "R3 cfg1");
        expect_val(K_RD, 8'h10, 32'h00657008, "R3 cfg2");
        expect_val(K_RD, 8'h14, 32'h12096806, "R3 cfg3");
        expect_val(K_RD, 8'h20, 32'h000D2345, "R3 cfg4");
        expect_val(K_RD, 8'h18, 32'hDEADBEEF, "R3 spread1");
        expect_val(K_RD, 8'h1C, 32'h0BADF00D, "R3 spread2");
        expect_val(K_RD, 8'h24, 32'h0, "R3 unmapped");
        // R4 nothing applied yet
        expect_val(K_REFDIV, 8'h00, 32'h0, "R4 refdiv before commit");
        expect_val(K_OUTEN, 8'h00, 32'h0, "R4 enables before commit");

        // R5/R6/R7/R9 first commit
        bus_write(8'h08, 32'h1);
        expect_val(K_RD, 8'h08, 32'h1, "R5 commit bit high");
        expect_val(K_RD, 8'h08, 32'h0, "R5 commit bit cleared");
        expect_val(K_REFDIV, 8'h00, 32'h3, "R6 refdiv");
        expect_val(K_LOCK, 8'h00, 32'h0, "R7 lock low while counting");
        expect_val(K_ACK, 8'h00, 32'h0, "R9 ack not yet");
        expect_val(K_ACK, 8'h00, 32'h3, "R9 ack after 4 edges");
        expect_val(K_LOCK, 8'h00, 32'h1, "R7 lock after D+1");
        expect_val(K_RD, 8'h04, 32'h183, "R9 status ack bits");
        expect_val(K_PDIV, 8'h00, 32'h01208303, "R6 post dividers");
        expect_val(K_FRAC, 8'h00, 32'h12345, "R6 fraction");
        expect_val(K_MISC, 8'h00, 32'h19E, "R6 config2 controls");
        expect_val(K_SD, 8'h00, 32'h5A, "R6 sigma-delta");
        expect_val(K_MULT, 8'h00, 32'h64, "R6 multiplier");
        expect_val(K_OUTEN, 8'h00, 32'h3, "R6 enables");

        // R8 restart of lock count
        bus_write(8'h08, 32'h1);
        expect_val(K_LOCK, 8'h00, 32'h0, "R8 lock cleared");
        idle(1);
        bus_write(8'h08, 32'h1);
        idle(5);
        expect_val(K_LOCK, 8'h00, 32'h0, "R8 count reloaded");
        expect_val(K_LOCK, 8'h00, 32'h1, "R8 lock after latest commit");

        // R10 bypass masks acks
        bus_write(8'h10, 32'h00757008);
        bus_write(8'h08, 32'h1);
        expect_val(K_ACK, 8'h00, 32'h3, "R10 ack before bypass applied");
        expect_val(K_ACK, 8'h00, 32'h0, "R10 ack masked at once");
        expect_val(K_MISC, 8'h00, 32'h19F, "R10 bypass output");
        expect_val(K_RD, 8'h04, 32'h1, "R10 status masked");
        idle(6);
        // R5 write with bit 0 clear ignored; R11 status read-only
        bus_write(8'h08, 32'h0);
        expect_val(K_RD, 8'h08, 32'h0, "R5 zero write no commit");
        expect_val(K_LOCK, 8'h00, 32'h1, "R5 lock kept");
        bus_write(8'h04, 32'hFFFFFFFF);
        expect_val(K_RD, 8'h04, 32'h3, "R11 status unchanged");

        idle(2);
        if (kind_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending", kind_q.size());
        end
        report();
    end
endmodule